// File: doc/BRIEF.md
# FP8 Indexed Dot-Product Accumulator

This block updates a vector of single-precision accumulators in one operation. Each 32-bit lane of the first source holds four 8-bit floating-point values. One 32-bit group of the second source, chosen by a 2-bit index, holds four more. That same group is shared by every lane. In each lane the four pairwise products are summed exactly and multiplied by 2^scale. The result is added to the lane's current accumulator value, with a single round-to-nearest-even step at the end. The new value replaces the accumulator value that was read.

Each operand picks its 8-bit encoding with its own select, so the two sources may use different formats. A width bit selects 64-bit operation (2 lanes) or 128-bit operation (4 lanes). The second source is always supplied as a full 128-bit vector.

Operands enter on a valid/ready stream and results leave on another. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` on the following cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` stays low. `in_ready` is high whenever the output register is empty or is being drained in the same cycle.

Top module: `fp8_dot_acc`

## Requirements
- R1: Each lane k (bits 32k+31:32k) produces acc + sum over j=0..3 of a[j]*b[j], where byte j sits at bits 8j+7:8j of the 32-bit group, rounded once to single precision with round-to-nearest-even.
- R2: The second-source group is bits 32*grp_idx+31:32*grp_idx of `src_b`, and the same group is used by every lane.
- R3: With `wide`=1 all four lanes are produced. With `wide`=0 lanes 0 and 1 are produced and bits 127:64 of `acc_out` are zero.
- R4: A format select of 0 means E5M2 (sign bit 7, exponent 6:2 with bias 15, mantissa 1:0). A select of 1 means E4M3 (sign bit 7, exponent 6:3 with bias 7, mantissa 2:0). `fmt_a` governs `src_a` and `fmt_b` governs the selected group of `src_b`, independently. Subnormal 8-bit inputs keep their exact value.
- R5: The four-term sum is multiplied by 2^scale, where `scale` is an unsigned 6-bit value from 0 to 63.
- R6: The sum, the scaling and the accumulation use no intermediate rounding. Ties round to the even significand, and any nonzero bits below the round position force rounding up when the round bit is set.
- R7: The lane result is 0x7FC00000 when any of these holds: an 8-bit input is NaN (E5M2 exponent 31 with a nonzero mantissa; E4M3 with low seven bits 0x7F), the accumulator is NaN, an infinity is multiplied by zero, or infinities of opposite sign meet.
- R8: An E5M2 infinity (exponent 31, mantissa 0) times a nonzero finite value gives an infinity whose sign is the XOR of the operand signs. An infinite accumulator with a finite sum passes through. E4M3 code 0x7E is the finite value 448.
- R9: When the four-term sum is exactly zero, including when nonzero terms cancel, the accumulator lane passes through bit for bit, which keeps -0 and subnormal values. When a nonzero sum cancels the accumulator exactly, the result is +0.
- R10: The output stream follows the valid/ready rules stated above: the result appears one cycle after acceptance and holds stable under back-pressure.
- R11: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set is valid |
| in_ready | output | 1 | Block can accept an operand set |
| src_a | input | 128 | First source, four FP8 values per lane |
| src_b | input | 128 | Second source, four 32-bit groups |
| acc_in | input | 128 | Accumulator lanes, single precision |
| grp_idx | input | 2 | Selected group of src_b |
| wide | input | 1 | 1: four lanes, 0: two lanes |
| fmt_a | input | 1 | Encoding of src_a (0 E5M2, 1 E4M3) |
| fmt_b | input | 1 | Encoding of src_b (0 E5M2, 1 E4M3) |
| scale | input | 6 | Power-of-two exponent applied to the sum |
| out_ready | input | 1 | Consumer accepts the result |
| out_valid | output | 1 | Result is valid |
| acc_out | output | 128 | Updated accumulator lanes |

## Verification
The bench targets rounding at the halfway point: 1 + 2^-24 must stay at 1.0, and it must round up when a further 2^-32 term is present. A design that rounded the partial sum before accumulating, or that dropped the sticky bits, would return the wrong last bit. It also swaps the two format selects with operands that decode differently in each format, so exchanged or shared selects produce visibly wrong magnitudes. Group-index tests, narrow mode with nonzero upper accumulators, NaN and infinity combinations, exact-zero sums over -0 and subnormal accumulators, and a held result under back-pressure expose a wrong broadcast lane, leaking upper lanes, missing default NaNs, flushed or re-signed zeros, and results that change or get lost while stalled.

// File: rtl/fp8dp_pkg.sv
package fp8dp_pkg;
  localparam int F8_W    = 8;
  localparam int GRP     = 4;
  localparam int LANE_W  = GRP * F8_W;
  localparam int SIG8_W  = 4;
  localparam int SCALE_W = 6;
  // bit 0 of the fixed-point sum weighs 2^-FIX_OFS (smallest product exponent)
  localparam int FIX_OFS = 32;
  // largest product fits below bit 66; four of them below bit 68
  localparam int FIX_W   = 2 * FIX_OFS + 2 * SIG8_W - 6 + 2;
  localparam int WIN_W   = FIX_W + 3;
  localparam int EXP_W   = 12;

  typedef struct packed {
    logic                nan;
    logic                inf;
    logic                zero;
    logic                sign;
    logic [SIG8_W-1:0]   sig;
    logic signed [5:0]   lsb_exp;
  } f8_t;

  function automatic f8_t f8_decode(input logic [F8_W-1:0] x, input logic e4m3);
    f8_t r;
    int  e;
    r.sign = x[7];
    if (e4m3) begin
      e         = int'(x[6:3]);
      r.sig     = {(e != 0), x[2:0]};
      r.lsb_exp = 6'((e == 0 ? 1 : e) - 10);
      r.nan     = (x[6:0] == 7'h7F);
      r.inf     = 1'b0;
      r.zero    = (x[6:0] == 7'h00);
    end else begin
      e         = int'(x[6:2]);
      r.sig     = {1'b0, (e != 0), x[1:0]};
      r.lsb_exp = 6'((e == 0 ? 1 : e) - 17);
      r.nan     = (e == 31) && (x[1:0] != 2'b00);
      r.inf     = (e == 31) && (x[1:0] == 2'b00);
      r.zero    = (x[6:0] == 7'h00);
    end
    return r;
  endfunction
endpackage

// File: rtl/fp8dp_norm.sv
module fp8dp_norm #(
  parameter int W  = 68,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] lz
);
  always_comb begin
    lz = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (din[i]) lz = CW'(W - 1 - i);
    end
  end
  assign dout = din << lz;
endmodule

// File: rtl/fp8dp_round.sv
module fp8dp_round import fp8dp_pkg::*; #(
  parameter int N_W = WIN_W + 1
) (
  input  logic                    sign,
  input  logic signed [EXP_W-1:0] top,
  input  logic [N_W-1:0]          mant,
  output logic [LANE_W-1:0]       res
);
  always_comb begin
    int             sub_sh;
    int             sh;
    int             biased;
    logic [N_W-1:0] m2;
    logic [23:0]    keep;
    logic           rb;
    logic           st;
    logic [31:0]    pk;
    sub_sh = -126 - int'(top);
    sh     = (sub_sh <= 0) ? 0 : ((sub_sh > N_W) ? N_W : sub_sh);
    m2     = mant >> sh;
    st     = ((m2 << sh) != mant);
    biased = (sub_sh > 0) ? 0 : int'(top) + 127;
    keep   = m2[N_W-1 -: 24];
    rb     = m2[N_W-25];
    st     = st | (|m2[N_W-26:0]);
    pk     = {1'b0, 8'(biased), keep[22:0]};
    pk     = pk + 32'(rb & (st | keep[0]));
    if (biased >= 255) pk = 32'h7F80_0000;
    res = {sign, pk[30:0]};
  end
endmodule

// File: rtl/fp8dp_lane.sv
module fp8dp_lane import fp8dp_pkg::*; (
  input  logic [LANE_W-1:0]  a_grp,
  input  logic [LANE_W-1:0]  b_grp,
  input  logic [LANE_W-1:0]  acc,
  input  logic               fmt_a,
  input  logic               fmt_b,
  input  logic [SCALE_W-1:0] scale,
  output logic [LANE_W-1:0]  res
);
  localparam int DLZ_W = $clog2(FIX_W + 1);
  localparam int SLZ_W = $clog2(WIN_W + 2);
  localparam logic [LANE_W-1:0] QNAN = 32'h7FC0_0000;

  logic signed [FIX_W+1:0] dot;
  logic                    any_nan, pinf, ninf;
  logic [FIX_W-1:0]        dmag, d_norm, a_mag, a_norm;
  logic [DLZ_W-1:0]        d_lz, a_lz;
  logic                    d_zero, a_zero;
  logic signed [EXP_W-1:0] big_top, r_top;
  logic                    r_sign;
  logic [WIN_W:0]          sum, s_norm;
  logic [SLZ_W-1:0]        s_lz;
  logic [LANE_W-1:0]       rounded;

  // exact products and special-value flags
  always_comb begin
    f8_t              xa, xb;
    logic [FIX_W-1:0] mag;
    logic [6:0]       sh;
    dot = '0; any_nan = 1'b0; pinf = 1'b0; ninf = 1'b0;
    for (int k = 0; k < GRP; k++) begin
      xa  = f8_decode(a_grp[k*F8_W +: F8_W], fmt_a);
      xb  = f8_decode(b_grp[k*F8_W +: F8_W], fmt_b);
      sh  = 7'(int'(xa.lsb_exp) + int'(xb.lsb_exp) + FIX_OFS);
      mag = FIX_W'({4'b0, xa.sig} * {4'b0, xb.sig}) << sh;
      if (xa.sign ^ xb.sign) dot = dot - $signed({2'b00, mag});
      else                   dot = dot + $signed({2'b00, mag});
      if (xa.nan || xb.nan) any_nan = 1'b1;
      if (xa.inf || xb.inf) begin
        if (xa.zero || xb.zero)  any_nan = 1'b1;
        else if (xa.sign ^ xb.sign) ninf = 1'b1;
        else                        pinf = 1'b1;
      end
    end
    if (acc[30:23] == 8'hFF) begin
      if (acc[22:0] != 23'd0) any_nan = 1'b1;
      else if (acc[31])        ninf = 1'b1;
      else                     pinf = 1'b1;
    end
  end

  assign dmag   = FIX_W'(dot[FIX_W+1] ? -dot : dot);
  assign d_zero = (dmag == '0);
  assign a_mag  = {(acc[30:23] != 8'd0), acc[22:0], {(FIX_W-24){1'b0}}};
  assign a_zero = (acc[30:0] == 31'd0);

  fp8dp_norm #(.W(FIX_W), .CW(DLZ_W)) u_norm_dot (.din(dmag),  .dout(d_norm), .lz(d_lz));
  fp8dp_norm #(.W(FIX_W), .CW(DLZ_W)) u_norm_acc (.din(a_mag), .dout(a_norm), .lz(a_lz));

  // align the smaller operand, keep a sticky bit, add or subtract
  always_comb begin
    int               d_top, a_top, s_top, diff, sh;
    logic             a_big, s_small;
    logic [FIX_W-1:0] m_big, m_small;
    logic [WIN_W-1:0] ext_b, ext_s, shf;
    d_top   = FIX_W - 1 - int'(d_lz) - FIX_OFS + int'(scale);
    a_top   = (acc[30:23] == 8'd0 ? 1 : int'(acc[30:23])) - 127 - int'(a_lz);
    a_big   = d_zero || (!a_zero && ((a_top > d_top) || ((a_top == d_top) && (a_norm >= d_norm))));
    m_big   = a_big ? a_norm : d_norm;
    m_small = a_big ? d_norm : a_norm;
    r_sign  = a_big ? acc[31] : dot[FIX_W+1];
    s_small = a_big ? dot[FIX_W+1] : acc[31];
    big_top = EXP_W'(a_big ? a_top : d_top);
    s_top   = a_big ? d_top : a_top;
    diff    = int'(big_top) - s_top;
    sh      = (diff < 0 || diff > WIN_W) ? WIN_W : diff;
    ext_b   = {m_big, 3'b000};
    ext_s   = {m_small, 3'b000};
    shf     = ext_s >> sh;
    if ((shf << sh) != ext_s) shf[0] = 1'b1;
    if (r_sign ^ s_small) sum = {1'b0, ext_b} - {1'b0, shf};
    else                  sum = {1'b0, ext_b} + {1'b0, shf};
  end

  fp8dp_norm #(.W(WIN_W + 1), .CW(SLZ_W)) u_norm_sum (.din(sum), .dout(s_norm), .lz(s_lz));

  assign r_top = EXP_W'(int'(big_top) + 1 - int'(s_lz));

  fp8dp_round #(.N_W(WIN_W + 1)) u_round (
    .sign(r_sign), .top(r_top), .mant(s_norm), .res(rounded)
  );

  always_comb begin
    if (any_nan || (pinf && ninf)) res = QNAN;
    else if (pinf)                 res = 32'h7F80_0000;
    else if (ninf)                 res = 32'hFF80_0000;
    else if (d_zero)               res = acc;
    else if (sum == '0)            res = '0;
    else                           res = rounded;
  end
endmodule

// File: rtl/fp8_dot_acc.sv
module fp8_dot_acc import fp8dp_pkg::*; #(
  parameter int VEC_W = 128,
  parameter int IDX_W = $clog2(VEC_W / LANE_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  input  logic [VEC_W-1:0]   acc_in,
  input  logic [IDX_W-1:0]   grp_idx,
  input  logic               wide,
  input  logic               fmt_a,
  input  logic               fmt_b,
  input  logic [SCALE_W-1:0] scale,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [VEC_W-1:0]   acc_out
);
  localparam int LANES = VEC_W / LANE_W;
  localparam int HALF  = LANES / 2;

  logic [LANE_W-1:0] b_sel;
  logic [LANE_W-1:0] lane_out [LANES];
  logic [VEC_W-1:0]  lane_res;

  assign b_sel    = src_b[int'(grp_idx)*LANE_W +: LANE_W];
  assign in_ready = !out_valid || out_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fp8dp_lane u_lane (
      .a_grp (src_a[g*LANE_W +: LANE_W]),
      .b_grp (b_sel),
      .acc   (acc_in[g*LANE_W +: LANE_W]),
      .fmt_a (fmt_a),
      .fmt_b (fmt_b),
      .scale (scale),
      .res   (lane_out[g])
    );
    if (g < HALF) begin : g_low
      assign lane_res[g*LANE_W +: LANE_W] = lane_out[g];
    end else begin : g_high
      assign lane_res[g*LANE_W +: LANE_W] = wide ? lane_out[g] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) acc_out <= lane_res;
    end
  end
endmodule

// File: rtl/fp8dp_chk.sv
module fp8dp_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [VEC_W-1:0] acc_in,
  input logic             wide,
  input logic             out_ready,
  input logic             out_valid,
  input logic [VEC_W-1:0] acc_out
);
  logic wide_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wide_q <= 1'b1;
    else if (in_valid && in_ready) wide_q <= wide;
  end

  p_empty_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(acc_out)));

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !wide_q) |-> (acc_out[VEC_W-1:VEC_W/2] == '0));

  p_acc_nan_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && acc_in[30:23] == 8'hFF && acc_in[22:0] != 23'd0)
      |=> (acc_out[31:0] == 32'h7FC0_0000));

  p_valid_origin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind fp8_dot_acc fp8dp_chk #(.VEC_W(VEC_W)) u_chk (.*);

// File: tb/fp8_dot_acc_tb.sv
`timescale 1ns/1ps
module fp8_dot_acc_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] src_a = '0, src_b = '0, acc_in = '0;
  logic [1:0]   grp_idx = '0;
  logic         wide = 1'b1, fmt_a = 1'b0, fmt_b = 1'b0;
  logic [5:0]   scale = '0;
  logic         out_ready = 1'b1;
  logic         out_valid;
  logic [127:0] acc_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fp8_dot_acc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .acc_in(acc_in), .grp_idx(grp_idx),
    .wide(wide), .fmt_a(fmt_a), .fmt_b(fmt_b), .scale(scale),
    .out_ready(out_ready), .out_valid(out_valid), .acc_out(acc_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] lane(input int k);
    return acc_out[k*32 +: 32];
  endfunction

  task automatic run(input logic [127:0] a, input logic [127:0] b, input logic [127:0] acc,
                     input logic [1:0] idx, input logic w, input logic fa, input logic fb,
                     input logic [5:0] sc);
    @(negedge clk);
    src_a = a; src_b = b; acc_in = acc; grp_idx = idx; wide = w;
    fmt_a = fa; fmt_b = fb; scale = sc; in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R11 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R11 in_ready after reset", 32'(in_ready), 32'd1);
  endtask

  task automatic t_basic;
    run({32'h00003C40, 32'hBCBCBCBC, 32'h40404040, 32'h3C3C3C3C},
        {96'h0, 32'h3C3C3C3C},
        {32'h3F000000, 32'h40800000, 32'h00000000, 32'h3F800000}, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0);
    chk("R1 lane0 4+1", lane(0), 32'h40A00000);
    chk("R1 lane1 eight", lane(1), 32'h41000000);
    chk("R9 cancel to +0", lane(2), 32'h00000000);
    chk("R1 lane3 3+0.5", lane(3), 32'h40600000);
    chk("R10 out_valid after accept", 32'(out_valid), 32'd1);
  endtask

  task automatic t_index;
    run({4{32'h3C3C3C3C}}, {32'h38383838, 32'h40404040, 32'h3C3C3C3C, 32'h00000000},
        '0, 2'd2, 1'b1, 1'b0, 1'b0, 6'd0);
    for (int k = 0; k < 4; k++) chk("R2 group 2 broadcast", lane(k), 32'h41000000);
    run({4{32'h3C3C3C3C}}, {32'h38383838, 32'h40404040, 32'h3C3C3C3C, 32'h00000000},
        '0, 2'd3, 1'b1, 1'b0, 1'b0, 6'd0);
    chk("R2 group 3 lane0", lane(0), 32'h40000000);
    chk("R2 group 3 lane3", lane(3), 32'h40000000);
  endtask

  task automatic t_narrow;
    run({4{32'h3C3C3C3C}}, {32'h38383838, 32'h40404040, 32'h3C3C3C3C, 32'h00000000},
        {4{32'h3F800000}}, 2'd2, 1'b0, 1'b0, 1'b0, 6'd0);
    chk("R3 narrow lane0", lane(0), 32'h41100000);
    chk("R3 narrow lane1", lane(1), 32'h41100000);
    chk("R3 narrow lane2 zero", lane(2), 32'h0);
    chk("R3 narrow lane3 zero", lane(3), 32'h0);
  endtask

  task automatic t_formats;
    run({64'h0, 32'h00000100, 32'h00000044}, {96'h0, 32'h00000138},
        '0, 2'd0, 1'b1, 1'b0, 1'b1, 6'd0);
    chk("R4 a=E5M2 b=E4M3", lane(0), 32'h40800000);
    chk("R4 subnormal product", lane(1), 32'h33000000);
    run({64'h0, 32'h00000100, 32'h00000044}, {96'h0, 32'h00000138},
        '0, 2'd0, 1'b1, 1'b1, 1'b0, 6'd0);
    chk("R4 a=E4M3 b=E5M2", lane(0), 32'h3FC00000);
    chk("R4 subnormal product swapped", lane(1), 32'h33000000);
  endtask

  task automatic t_scale;
    run({64'h0, 32'h0000003C, 32'h3C3C3C3C}, {96'h0, 32'h3C3C3C3C},
        '0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd3);
    chk("R5 scale 3", lane(0), 32'h42000000);
    run({64'h0, 32'h0000003C, 32'h3C3C3C3C}, {96'h0, 32'h3C3C3C3C},
        '0, 2'd0, 1'b1, 1'b0, 1'b0, 6'd63);
    chk("R5 scale 63 lane0", lane(0), 32'h60000000);
    chk("R5 scale 63 lane1", lane(1), 32'h5F000000);
  endtask

  task automatic t_round;
    run({32'h0000000C, 32'h0000810C, 32'h0000000C, 32'h0000010C}, {96'h0, 32'h0000010C},
        {32'h3F800001, {3{32'h3F800000}}}, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0);
    chk("R6 above half rounds up", lane(0), 32'h3F800001);
    chk("R6 tie to even stays", lane(1), 32'h3F800000);
    chk("R6 below half stays", lane(2), 32'h3F800000);
    chk("R6 tie to even from odd", lane(3), 32'h3F800002);
  endtask

  task automatic t_special;
    run({32'h3C3C3C3C, 32'h00007CFC, 32'h0000007C, 32'h0000007E}, {96'h0, 32'h3C3C3C3C},
        {32'hFF800000, 32'h0, 32'h3F800000, 32'h0}, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0);
    chk("R7 E5M2 NaN input", lane(0), 32'h7FC00000);
    chk("R8 inf times one", lane(1), 32'h7F800000);
    chk("R7 opposite infinities", lane(2), 32'h7FC00000);
    chk("R8 negative inf accumulator", lane(3), 32'hFF800000);
    run({32'h000000FC, 32'h0000003C, 32'h0, 32'h00007C00}, {96'h0, 32'h0000003C},
        {32'h7F800000, 32'h7F800000, 32'h7F800001, 32'h0}, 2'd0, 1'b1, 1'b0, 1'b0, 6'd0);
    chk("R7 inf times zero", lane(0), 32'h7FC00000);
    chk("R7 NaN accumulator", lane(1), 32'h7FC00000);
    chk("R8 inf accumulator passes", lane(2), 32'h7F800000);
    chk("R7 -inf product plus +inf acc", lane(3), 32'h7FC00000);
    run({32'h00000078, 32'h000000FF, 32'h0000007E, 32'h0000007F}, {96'h0, 32'h0000003C},
        '0, 2'd0, 1'b1, 1'b1, 1'b0, 6'd0);
    chk("R7 E4M3 NaN", lane(0), 32'h7FC00000);
    chk("R8 E4M3 0x7E finite", lane(1), 32'h43E00000);
    chk("R7 E4M3 negative NaN", lane(2), 32'h7FC00000);
    chk("R4 E4M3 256", lane(3), 32'h43800000);
  endtask

  task automatic t_zero_sum;
    run({32'h0000BC3C, 32'h0, 32'h0, 32'h0}, {96'h0, 32'h3C3C3C3C},
        {32'h80000000, 32'h12345678, 32'h00000005, 32'h80000000}, 2'd0, 1'b1, 1'b0, 1'b0, 6'd9);
    chk("R9 -0 kept", lane(0), 32'h80000000);
    chk("R9 subnormal kept", lane(1), 32'h00000005);
    chk("R9 normal kept", lane(2), 32'h12345678);
    chk("R9 cancelling terms keep -0", lane(3), 32'h80000000);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    @(negedge clk);
    src_a = {4{32'h3C3C3C3C}}; src_b = {96'h0, 32'h3C3C3C3C}; acc_in = '0;
    grp_idx = 2'd0; wide = 1'b1; fmt_a = 1'b0; fmt_b = 1'b0; scale = 6'd0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    acc_in = {96'h0, 32'h3F800000};
    chk("R10 valid under stall", 32'(out_valid), 32'd1);
    chk("R10 not ready under stall", 32'(in_ready), 32'd0);
    chk("R10 first result", lane(0), 32'h40800000);
    repeat (2) @(negedge clk);
    chk("R10 result held", lane(0), 32'h40800000);
    chk("R10 still not ready", 32'(in_ready), 32'd0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 second result after drain", lane(0), 32'h40A00000);
    chk("R10 valid for second", 32'(out_valid), 32'd1);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_index();
    t_narrow();
    t_formats();
    t_scale();
    t_round();
    t_special();
    t_zero_sum();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule